// File: doc/BRIEF.md
# Handshake Serial Byte Transfer Engine

This block sits between a host processor and a system controller and moves bytes in both directions over a shift-register data path. Three active-low handshake lines set the pace. The host drives a busy line (a transfer is in progress while it is low) and an acknowledge line. The block drives a request line back. The block acts only when the host writes the port, which it sees as a one-cycle strobe carrying the new line levels. On each strobe it compares the busy/acknowledge pair with the pair from the previous strobe and decides what to do.

While the host sends, each changed pair appends the shift-register input byte to a 16-entry receive buffer. When busy rises again, the block pulses a packet-complete strobe with the byte count for the command layer. While the host receives, each changed pair loads the next byte of a pending response into the shift-register output. Every byte move and every handshake event schedules a shift-register interrupt, which fires as a single pulse after a fixed 20 µs delay. The block also tells the peripheral bus when to stop background polling: the block output is asserted while a host exchange is under way.

Top module: `hsx_engine`

## Requirements
- R1: After reset: `req_n` is 1, `ap_block` is 0, `sr_irq` is 0, `pkt_done` is 0 and `sr_out` is 0. The handshake pair remembered from the previous write reads busy high and acknowledge high.
- R2: With `hs_busy_n` low and `sr_dir_out` 1, a port write whose (`hs_busy_n`, `hs_ack_n`) pair differs from the pair of the previous port write stores `sr_in` at the next receive index. A write with an unchanged pair stores nothing. Stored bytes can be read back on `rx_rd_byte` at index `rx_rd_idx`, counted from 0.
- R3: Once 16 bytes are held, any further host byte is dropped. A dropped byte schedules no interrupt and overwrites nothing.
- R4: `ap_block` goes to 1 when a host byte is stored into an empty receive buffer.
- R5: A port write with busy high that follows a write with busy low ends the transfer. If at least one byte was received, `pkt_done` pulses for one cycle and `pkt_len` gives the byte count; with zero bytes there is no pulse. The receive count returns to zero, and an interrupt is scheduled in both cases.
- R6: With `hs_busy_n` low and `sr_dir_out` 0, each changed pair loads the next pending response byte into `sr_out`, in order. A changed pair with nothing pending leaves `sr_out` as it is.
- R7: When the last pending response byte is delivered, `req_n` goes to 1 and `ap_block` goes to 0.
- R8: A port write with busy high whose previous write also had busy high, and whose acknowledge level has changed, copies the new acknowledge level onto `req_n` and schedules an interrupt.
- R9: While response bytes are pending, `req_n` is driven to 0 in two cases: by an idle port write (busy high, not an acknowledge change) or by the write that ends a transfer, and by a `rsp_load` of nonzero length issued while the last written busy level was high. A `rsp_load` issued while busy is low leaves `req_n` unchanged.
- R10: `sr_irq` is a one-cycle pulse that rises exactly DELAY_CYC (CLK_MHZ × DELAY_US, 2500 by default) clock cycles after the edge that scheduled it. A new trigger restarts the count, so the earlier trigger gives no pulse.
- R11: `rsp_load` sets the pending length to `rsp_len`, restarts the read position at byte 0 and schedules an interrupt. Loading again without rewriting the bytes replays the response from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_wr | input | 1 | One-cycle strobe: host wrote the handshake port |
| hs_busy_n | input | 1 | Transfer-in-progress level, active low (sampled on hs_wr) |
| hs_ack_n | input | 1 | Acknowledge level, active low (sampled on hs_wr) |
| sr_dir_out | input | 1 | Shift direction: 1 host-to-device, 0 device-to-host |
| sr_in | input | 8 | Shift-register byte written by the host |
| sr_out | output | 8 | Shift-register byte presented to the host |
| req_n | output | 1 | Transfer-request line, active low |
| rsp_wr | input | 1 | Write one response byte |
| rsp_wr_idx | input | $clog2(DEPTH) | Response byte position |
| rsp_wr_byte | input | 8 | Response byte value |
| rsp_load | input | 1 | Commit a response of rsp_len bytes (must not coincide with hs_wr) |
| rsp_len | input | $clog2(DEPTH)+1 | Response length in bytes |
| rx_rd_idx | input | $clog2(DEPTH) | Receive buffer read position |
| rx_rd_byte | output | 8 | Receive buffer byte at rx_rd_idx |
| pkt_done | output | 1 | One-cycle packet-complete strobe |
| pkt_len | output | $clog2(DEPTH)+1 | Byte count of the completed packet |
| ap_block | output | 1 | Hold off background bus polling |
| sr_irq | output | 1 | Delayed shift-register interrupt pulse |

## Verification
The hardest case to reach is the interrupt restart. Two triggers have to land inside one delay window, and the bench then has to show that only the later one produces a pulse. The stimulus issues one acknowledge toggle with busy high, waits part of the window, then toggles again. It measures the cycles from the second edge to the pulse and counts all pulses. The overflow drop is the other hard case, because it needs sixteen stored bytes before a seventeenth can be dropped. Once the pending interrupt has drained, the bench shows the drop silently by the absence of any new pulse and by the unchanged last buffer entry.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

    typedef struct packed {
        logic busy_n;
        logic ack_n;
    } hs_pins_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_H2D,
        EV_D2H,
        EV_SYNC,
        EV_END,
        EV_IDLE
    } hs_event_t;

    // Decide what one port write means, given the pair seen at the write before.
    function automatic hs_event_t hs_classify(hs_pins_t now, hs_pins_t prev, logic dir_out);
        hs_event_t ev;
        if (!now.busy_n) begin
            if (now != prev) ev = dir_out ? EV_H2D : EV_D2H;
            else             ev = EV_NONE;
        end else if (!prev.busy_n) begin
            ev = EV_END;
        end else if (now.ack_n != prev.ack_n) begin
            ev = EV_SYNC;
        end else begin
            ev = EV_IDLE;
        end
        return ev;
    endfunction

endpackage

// File: rtl/hsx_sr_delay.sv
module hsx_sr_delay #(
    parameter int DELAY_CYC = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic irq
);
    localparam int CW = $clog2(DELAY_CYC + 1);

    logic [CW-1:0] cnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (trig) begin
                cnt   <= CW'(DELAY_CYC);
                armed <= 1'b1;
            end else if (armed) begin
                if (cnt == CW'(1)) begin
                    irq   <= 1'b1;
                    armed <= 1'b0;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    // R10: the interrupt is never wider than one cycle
    p_irq_single_r10: assert property (@(posedge clk) disable iff (rst) irq |=> !irq);

endmodule

// File: rtl/hsx_rx_buf.sv
module hsx_rx_buf #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic [7:0]               data,
    input  logic                     clear,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [7:0]               rd_byte,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     full
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic [7:0] mem [DEPTH];

    assign full    = (count == CNT_W'(DEPTH));
    assign rd_byte = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (push && !full) begin
            mem[count[IDX_W-1:0]] <= data;
            count <= count + CNT_W'(1);
        end
    end

    // R3: the fill count never exceeds the buffer depth
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(DEPTH));
    // R3: a push into a full buffer leaves the count at depth
    p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (full && push && !clear) |=> (count == CNT_W'(DEPTH)));

endmodule

// File: rtl/hsx_tx_buf.sv
module hsx_tx_buf #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [7:0]               wr_byte,
    input  logic                     load,
    input  logic [$clog2(DEPTH):0]   len,
    input  logic                     pop,
    output logic [7:0]               cur_byte,
    output logic                     pending,
    output logic                     last
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic [7:0]       mem [DEPTH];
    logic [CNT_W-1:0] size;
    logic [CNT_W-1:0] idx;

    assign pending  = (idx < size);
    assign last     = ({1'b0, idx} + (CNT_W+1)'(1)) >= {1'b0, size};
    assign cur_byte = mem[idx[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (wr) mem[wr_idx] <= wr_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            size <= '0;
            idx  <= '0;
        end else if (load) begin
            size <= (len > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : len;
            idx  <= '0;
        end else if (pop && pending) begin
            idx <= idx + CNT_W'(1);
        end
    end

    // R6: the read position never runs past the pending length
    p_idx_bound_r6: assert property (@(posedge clk) disable iff (rst) idx <= size);
    // R11: a load always restarts reading from byte zero
    p_load_restart_r11: assert property (@(posedge clk) disable iff (rst) load |=> (idx == '0));

endmodule

// File: rtl/hsx_engine.sv
module hsx_engine
    import hsx_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int CLK_MHZ  = 125,
    parameter int DELAY_US = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hs_wr,
    input  logic                     hs_busy_n,
    input  logic                     hs_ack_n,
    input  logic                     sr_dir_out,
    input  logic [7:0]               sr_in,
    output logic [7:0]               sr_out,
    output logic                     req_n,
    input  logic                     rsp_wr,
    input  logic [$clog2(DEPTH)-1:0] rsp_wr_idx,
    input  logic [7:0]               rsp_wr_byte,
    input  logic                     rsp_load,
    input  logic [$clog2(DEPTH):0]   rsp_len,
    input  logic [$clog2(DEPTH)-1:0] rx_rd_idx,
    output logic [7:0]               rx_rd_byte,
    output logic                     pkt_done,
    output logic [$clog2(DEPTH):0]   pkt_len,
    output logic                     ap_block,
    output logic                     sr_irq
);
    localparam int IDX_W     = $clog2(DEPTH);
    localparam int CNT_W     = IDX_W + 1;
    localparam int DELAY_CYC = CLK_MHZ * DELAY_US;

    hs_pins_t         last_pins;
    hs_pins_t         cur_pins;
    hs_event_t        ev;
    logic             rx_push, rx_clear, rx_full;
    logic [CNT_W-1:0] rx_count;
    logic             tx_pop, tx_load, tx_pending, tx_last;
    logic [7:0]       tx_byte;
    logic             trig;

    assign cur_pins = '{busy_n: hs_busy_n, ack_n: hs_ack_n};
    assign ev       = hs_wr ? hs_classify(cur_pins, last_pins, sr_dir_out) : EV_NONE;

    assign rx_push  = (ev == EV_H2D) && !rx_full;
    assign rx_clear = (ev == EV_END);
    assign tx_pop   = (ev == EV_D2H) && tx_pending;
    assign tx_load  = rsp_load && !hs_wr;
    assign trig     = rx_push || tx_pop || (ev == EV_SYNC) || (ev == EV_END) || tx_load;

    hsx_rx_buf #(.DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst(rst), .push(rx_push), .data(sr_in), .clear(rx_clear),
        .rd_idx(rx_rd_idx), .rd_byte(rx_rd_byte), .count(rx_count), .full(rx_full)
    );

    hsx_tx_buf #(.DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst(rst), .wr(rsp_wr), .wr_idx(rsp_wr_idx), .wr_byte(rsp_wr_byte),
        .load(tx_load), .len(rsp_len), .pop(tx_pop),
        .cur_byte(tx_byte), .pending(tx_pending), .last(tx_last)
    );

    hsx_sr_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
        .clk(clk), .rst(rst), .trig(trig), .irq(sr_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pins <= '{busy_n: 1'b1, ack_n: 1'b1};
            req_n     <= 1'b1;
            ap_block  <= 1'b0;
            sr_out    <= '0;
            pkt_done  <= 1'b0;
            pkt_len   <= '0;
        end else begin
            pkt_done <= 1'b0;
            if (hs_wr) last_pins <= cur_pins;
            case (ev)
                EV_H2D: begin
                    if (rx_push && rx_count == '0) ap_block <= 1'b1;
                end
                EV_D2H: begin
                    if (tx_pop) begin
                        sr_out <= tx_byte;
                        if (tx_last) begin
                            req_n    <= 1'b1;
                            ap_block <= 1'b0;
                        end
                    end
                end
                EV_SYNC: req_n <= hs_ack_n;
                EV_END: begin
                    pkt_done <= (rx_count != '0);
                    pkt_len  <= rx_count;
                    if (tx_pending) req_n <= 1'b0;
                end
                EV_IDLE: begin
                    if (tx_pending) req_n <= 1'b0;
                end
                default: begin
                    if (tx_load && last_pins.busy_n && rsp_len != '0) req_n <= 1'b0;
                end
            endcase
        end
    end

    // R5: a completion strobe always reports a nonempty packet
    p_done_len_r5: assert property (@(posedge clk) disable iff (rst) pkt_done |-> (pkt_len != '0));
    // R6: the shift output only moves in response to a port write
    p_sr_hold_r6: assert property (@(posedge clk) disable iff (rst) !$past(hs_wr) |-> $stable(sr_out));
    // R4: polling is blocked only by a host-to-device byte during a transfer
    p_block_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(ap_block) |-> ($past(hs_wr) && $past(sr_dir_out) && !$past(hs_busy_n)));
    // R7: the request line is released only by a port write
    p_req_release_r7: assert property (@(posedge clk) disable iff (rst) $rose(req_n) |-> $past(hs_wr));

endmodule

// File: tb/sim_hsx_engine.sv
module sim_hsx_engine;
    localparam int DEPTH = 16;
    localparam int DLY   = 125 * 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hs_wr = 1'b0, hs_busy_n = 1'b1, hs_ack_n = 1'b1, sr_dir_out = 1'b0;
    logic [7:0] sr_in = '0;
    logic [7:0] sr_out;
    logic       req_n;
    logic       rsp_wr = 1'b0;
    logic [3:0] rsp_wr_idx = '0;
    logic [7:0] rsp_wr_byte = '0;
    logic       rsp_load = 1'b0;
    logic [4:0] rsp_len = '0;
    logic [3:0] rx_rd_idx = '0;
    logic [7:0] rx_rd_byte;
    logic       pkt_done;
    logic [4:0] pkt_len;
    logic       ap_block;
    logic       sr_irq;

    int tests = 0;
    int fails = 0;
    int irq_cnt = 0;
    int exp_len_q[$];

    always #4 clk = ~clk;

    hsx_engine #(.DEPTH(DEPTH), .CLK_MHZ(125), .DELAY_US(20)) u0 (
        .clk(clk), .rst(rst), .hs_wr(hs_wr), .hs_busy_n(hs_busy_n), .hs_ack_n(hs_ack_n),
        .sr_dir_out(sr_dir_out), .sr_in(sr_in), .sr_out(sr_out), .req_n(req_n),
        .rsp_wr(rsp_wr), .rsp_wr_idx(rsp_wr_idx), .rsp_wr_byte(rsp_wr_byte),
        .rsp_load(rsp_load), .rsp_len(rsp_len), .rx_rd_idx(rx_rd_idx), .rx_rd_byte(rx_rd_byte),
        .pkt_done(pkt_done), .pkt_len(pkt_len), .ap_block(ap_block), .sr_irq(sr_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every completion strobe must match the next expected length
    always @(negedge clk) begin
        if (!rst && sr_irq) irq_cnt++;
        if (!rst && pkt_done) begin
            if (exp_len_q.size() == 0) begin
                chk(1'b0, "R5 unexpected pkt_done", int'(pkt_len), 0);
            end else begin
                int e;
                e = exp_len_q.pop_front();
                chk(int'(pkt_len) == e, "R5 pkt_len", int'(pkt_len), e);
            end
        end
    end

    task automatic port_wr(input logic b, input logic a, input logic dir, input logic [7:0] d);
        @(negedge clk);
        hs_wr = 1'b1; hs_busy_n = b; hs_ack_n = a; sr_dir_out = dir; sr_in = d;
        @(negedge clk);
        hs_wr = 1'b0;
    endtask

    task automatic rsp_fill(input int idx, input logic [7:0] v);
        @(negedge clk);
        rsp_wr = 1'b1; rsp_wr_idx = 4'(idx); rsp_wr_byte = v;
        @(negedge clk);
        rsp_wr = 1'b0;
    endtask

    task automatic rsp_commit(input int len);
        @(negedge clk);
        rsp_load = 1'b1; rsp_len = 5'(len);
        @(negedge clk);
        rsp_load = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_irq(input string req);
        int n = 0;
        while (!sr_irq && n < DLY + 50) begin
            @(negedge clk);
            n++;
        end
        chk(n == DLY, req, n, DLY);
    endtask

    task automatic rx_check(input int idx, input logic [7:0] exp, input string req);
        rx_rd_idx = 4'(idx);
        #1;
        chk(rx_rd_byte == exp, req, int'(rx_rd_byte), int'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int c0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_n == 1'b1, "R1 req_n", int'(req_n), 1);
        chk(ap_block == 1'b0, "R1 ap_block", int'(ap_block), 0);
        chk(sr_irq == 1'b0, "R1 sr_irq", int'(sr_irq), 0);
        chk(pkt_done == 1'b0, "R1 pkt_done", int'(pkt_done), 0);
        chk(sr_out == 8'h00, "R1 sr_out", int'(sr_out), 0);

        // R2 / R4: three host bytes, one repeated pair ignored
        port_wr(1'b0, 1'b1, 1'b1, 8'hA1);
        chk(ap_block == 1'b1, "R4 ap_block on first byte", int'(ap_block), 1);
        port_wr(1'b0, 1'b0, 1'b1, 8'hA2);
        port_wr(1'b0, 1'b1, 1'b1, 8'hA3);
        port_wr(1'b0, 1'b1, 1'b1, 8'hEE);
        exp_len_q.push_back(3);
        port_wr(1'b1, 1'b1, 1'b1, 8'h00);
        rx_check(0, 8'hA1, "R2 byte0");
        rx_check(1, 8'hA2, "R2 byte1");
        rx_check(2, 8'hA3, "R2 byte2");
        measure_irq("R10 irq delay after end");

        // R5: transfer with no bytes gives no strobe but still an interrupt
        port_wr(1'b0, 1'b1, 1'b0, 8'h00);
        port_wr(1'b1, 1'b1, 1'b0, 8'h00);
        measure_irq("R5 irq on empty end");

        // R3: overflow drop
        for (int i = 0; i < DEPTH; i++)
            port_wr(1'b0, (i % 2 == 0) ? 1'b1 : 1'b0, 1'b1, 8'(8'h10 + i));
        idle(DLY + 100);
        c0 = irq_cnt;
        port_wr(1'b0, 1'b1, 1'b1, 8'hFF);
        idle(DLY + 100);
        chk(irq_cnt == c0, "R3 no irq for dropped byte", irq_cnt, c0);
        exp_len_q.push_back(16);
        port_wr(1'b1, 1'b1, 1'b1, 8'h00);
        rx_check(15, 8'h1F, "R3 last entry kept");
        rx_check(0, 8'h10, "R3 first entry kept");

        // R9 / R6 / R7: response delivery
        rsp_fill(0, 8'hC1); rsp_fill(1, 8'hC2); rsp_fill(2, 8'hC3);
        rsp_commit(3);
        chk(req_n == 1'b0, "R9 req_n after idle load", int'(req_n), 0);
        port_wr(1'b0, 1'b1, 1'b0, 8'h00);
        chk(sr_out == 8'hC1, "R6 first byte", int'(sr_out), 'hC1);
        chk(req_n == 1'b0, "R7 req_n still low", int'(req_n), 0);
        port_wr(1'b0, 1'b0, 1'b0, 8'h00);
        chk(sr_out == 8'hC2, "R6 second byte", int'(sr_out), 'hC2);
        port_wr(1'b0, 1'b1, 1'b0, 8'h00);
        chk(sr_out == 8'hC3, "R6 third byte", int'(sr_out), 'hC3);
        chk(req_n == 1'b1, "R7 req_n released", int'(req_n), 1);
        chk(ap_block == 1'b0, "R7 ap_block released", int'(ap_block), 0);
        port_wr(1'b0, 1'b0, 1'b0, 8'h00);
        chk(sr_out == 8'hC3, "R6 nothing pending", int'(sr_out), 'hC3);
        port_wr(1'b1, 1'b1, 1'b0, 8'h00);

        // R8 / R10: acknowledge sync and interrupt restart
        idle(DLY + 100);
        port_wr(1'b1, 1'b0, 1'b0, 8'h00);
        chk(req_n == 1'b0, "R8 req follows ack low", int'(req_n), 0);
        idle(1000);
        c0 = irq_cnt;
        port_wr(1'b1, 1'b1, 1'b0, 8'h00);
        chk(req_n == 1'b1, "R8 req follows ack high", int'(req_n), 1);
        measure_irq("R10 restart delay");
        @(negedge clk);
        chk(irq_cnt == c0 + 1, "R10 single pulse after restart", irq_cnt, c0 + 1);

        // R9: load during a transfer, announce at end
        port_wr(1'b0, 1'b1, 1'b1, 8'h55);
        rsp_fill(0, 8'hE1); rsp_fill(1, 8'hE2);
        rsp_commit(2);
        chk(req_n == 1'b1, "R9 no announce while busy", int'(req_n), 1);
        exp_len_q.push_back(1);
        port_wr(1'b1, 1'b1, 1'b1, 8'h00);
        chk(req_n == 1'b0, "R9 announce at end", int'(req_n), 0);

        // R11: reload replays from byte zero
        port_wr(1'b0, 1'b1, 1'b0, 8'h00);
        chk(sr_out == 8'hE1, "R11 first read", int'(sr_out), 'hE1);
        port_wr(1'b1, 1'b1, 1'b0, 8'h00);
        rsp_commit(2);
        port_wr(1'b0, 1'b1, 1'b0, 8'h00);
        chk(sr_out == 8'hE1, "R11 replay byte0", int'(sr_out), 'hE1);
        port_wr(1'b0, 1'b0, 1'b0, 8'h00);
        chk(sr_out == 8'hE2, "R11 replay byte1", int'(sr_out), 'hE2);
        port_wr(1'b1, 1'b1, 1'b0, 8'h00);

        idle(DLY + 100);
        chk(exp_len_q.size() == 0, "R5 all packets seen", exp_len_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule